// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Unit

This block is a pipelined arithmetic unit for 16-bit floating-point numbers (1 sign bit, 5 exponent bits, 10 fraction bits, bias 15). Every operation passes through one fused multiply-add path. Multiply-add and multiply-subtract are native. Addition and subtraction replace the multiplier operand with 1.0. Multiplication replaces the addend with 0.0. The full-width product goes into the add stage without shortening, so each result is truncated once.

The caller presents three operands `a`, `b` and `c` together with an opcode and raises `in_valid` for one cycle. The result comes out on `d`, marked by `out_valid`, a fixed three cycles later. A new operation may be issued on every cycle. Results are truncated toward zero. Subnormal inputs and subnormal results are treated as zero. Overflow clamps to the largest finite value. Infinity and NaN encodings are not treated specially: an exponent field of 31 is decoded like any other exponent.

Top module: `hmac_unit`

## Requirements
- R1: With opcode 0 the result is a + b*c. Opcodes 5, 6 and 7 behave the same way as opcode 0.
- R2: With opcode 1 the result is a - b*c.
- R3: With opcode 2 the result is a + b, and the value on `c` has no effect.
- R4: With opcode 3 the result is a - b, and the value on `c` has no effect.
- R5: With opcode 4 the result is b*c, and the value on `a` has no effect.
- R6: An operation sampled with `in_valid` high at a clock edge gives `out_valid` high with its result exactly three edges later, never earlier. Operations issued on consecutive cycles produce results on consecutive cycles.
- R7: The exact value a ± b*c is truncated toward zero once, with no intermediate rounding of the product. Example: 4.0 - (1+2^-10)·0.25·(1+2^-10) gives 0x437F.
- R8: An input whose exponent field is 0 counts as zero. A result whose magnitude is below 2^-14 becomes zero carrying the sign of the exact result (0x8000 when that sign is negative).
- R9: A result whose magnitude would need an exponent field of 31 or more saturates to 0x7BFF, or to 0xFBFF when negative. No output ever has exponent field 31.
- R10: A sum that cancels exactly gives +0 (0x0000).
- R11: While `rst` is high, and after it until the first issue, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation issue strobe |
| op | input | 3 | Opcode: 0 mul-add, 1 mul-sub, 2 add, 3 sub, 4 mul |
| a | input | 16 | Addend operand |
| b | input | 16 | First multiplicand |
| c | input | 16 | Second multiplicand |
| out_valid | output | 1 | Result strobe |
| d | output | 16 | Result |

## Verification
The hardest case to reach is an effective subtraction in which the smaller term is shifted far enough that its low bits are lost. In that case the truncated result must be one unit below what rounding would give. The stimulus produces it by subtracting a product whose exact 22-bit mantissa has a set bit far below the result LSB from an addend four binades larger. Only a correct borrow from the sticky bit then yields 0x437F instead of 0x4380. Saturation and flush to signed zero are reached from the ports with products of extreme exponents.

// File: rtl/hmac_pkg.sv
`timescale 1ns/1ps
package hmac_pkg;
  typedef enum logic [2:0] {
    OP_FMA  = 3'd0,
    OP_FMS  = 3'd1,
    OP_SUM  = 3'd2,
    OP_DIFF = 3'd3,
    OP_PROD = 3'd4
  } hmac_op_e;
endpackage

// File: rtl/hmac_mul_stage.sv
`timescale 1ns/1ps
module hmac_mul_stage #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int PW   = 2 * (MAN_W + 1),
  localparam int XW   = EXP_W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  input  logic [W-1:0]         c,
  output logic                 v_q,
  output logic                 p_sign_q,
  output logic                 p_zero_q,
  output logic signed [XW-1:0] p_exp_q,
  output logic [PW-1:0]        p_man_q,
  output logic                 s_sign_q,
  output logic                 s_zero_q,
  output logic signed [XW-1:0] s_exp_q,
  output logic [MAN_W:0]       s_man_q
);
  import hmac_pkg::*;

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [W-1:0] ONE_VAL = {1'b0, EXP_W'(BIAS), {MAN_W{1'b0}}};

  logic [W-1:0]     a_use, c_use;
  logic             negate;
  logic [EXP_W-1:0] ea, eb, ec;
  logic             za, zb, zc;
  logic signed [XW-1:0] pe;
  logic [PW-1:0]    pm;

  always_comb begin
    a_use  = (op == OP_PROD) ? '0 : a;
    c_use  = (op == OP_SUM || op == OP_DIFF) ? ONE_VAL : c;
    negate = (op == OP_FMS || op == OP_DIFF);
    ea = a_use[W-2 -: EXP_W];
    eb = b[W-2 -: EXP_W];
    ec = c_use[W-2 -: EXP_W];
    za = (ea == '0);
    zb = (eb == '0);
    zc = (ec == '0);
    pe = XW'(eb) + XW'(ec) - XW'(BIAS);
    pm = PW'({1'b1, b[MAN_W-1:0]}) * PW'({1'b1, c_use[MAN_W-1:0]});
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;
    p_sign_q <= b[W-1] ^ c_use[W-1] ^ negate;
    p_zero_q <= zb | zc;
    p_exp_q  <= pe;
    p_man_q  <= pm;
    s_sign_q <= a_use[W-1];
    s_zero_q <= za;
    s_exp_q  <= XW'(ea);
    s_man_q  <= {1'b1, a_use[MAN_W-1:0]};
  end

  // R5
  prod_addend_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_PROD) |=> s_zero_q);
endmodule

// File: rtl/hmac_align_add.sv
`timescale 1ns/1ps
module hmac_align_add #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int GUARD = 3,
  localparam int PW   = 2 * (MAN_W + 1),
  localparam int XW   = EXP_W + 3,
  localparam int SW   = PW + GUARD + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic                 p_sign,
  input  logic                 p_zero,
  input  logic signed [XW-1:0] p_exp,
  input  logic [PW-1:0]        p_man,
  input  logic                 s_sign,
  input  logic                 s_zero,
  input  logic signed [XW-1:0] s_exp,
  input  logic [MAN_W:0]       s_man,
  output logic                 v_q,
  output logic                 sign_q,
  output logic signed [XW-1:0] ebig_q,
  output logic [SW-1:0]        sum_q
);
  function automatic logic [SW-1:0] shr_sticky(input logic [SW-1:0] v,
                                               input logic [XW-1:0] sh);
    logic [SW-1:0] lost;
    if (32'(sh) >= SW) return {{(SW-1){1'b0}}, |v};
    lost = v & ~({SW{1'b1}} << sh);
    return (v >> sh) | {{(SW-1){1'b0}}, |lost};
  endfunction

  logic [SW-1:0]        pm_ext, sm_ext, pa, sa, mag;
  logic signed [XW-1:0] diff, ebig;
  logic [XW-1:0]        shamt;
  logic                 sgn;

  always_comb begin
    pm_ext = p_zero ? '0 : (SW'(p_man) << GUARD);
    sm_ext = s_zero ? '0 : (SW'(s_man) << (MAN_W + GUARD));
    diff   = p_exp - s_exp;
    shamt  = diff[XW-1] ? XW'(-diff) : XW'(diff);
    if (p_zero && s_zero) begin
      pa = '0; sa = '0; ebig = '0;
    end else if (p_zero) begin
      pa = '0; sa = sm_ext; ebig = s_exp;
    end else if (s_zero) begin
      pa = pm_ext; sa = '0; ebig = p_exp;
    end else if (!diff[XW-1]) begin
      pa = pm_ext; sa = shr_sticky(sm_ext, shamt); ebig = p_exp;
    end else begin
      pa = shr_sticky(pm_ext, shamt); sa = sm_ext; ebig = s_exp;
    end
    if (p_sign == s_sign) begin
      mag = pa + sa;
      sgn = p_sign;
    end else if (pa >= sa) begin
      mag = pa - sa;
      sgn = p_sign;
    end else begin
      mag = sa - pa;
      sgn = s_sign;
    end
    if (mag == '0) sgn = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
    sign_q <= sgn;
    ebig_q <= ebig;
    sum_q  <= mag;
  end

  // R6
  stage_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (v_q == $past(v_in)));
endmodule

// File: rtl/hmac_normalize.sv
`timescale 1ns/1ps
module hmac_normalize #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int GUARD = 3,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int PW   = 2 * (MAN_W + 1),
  localparam int XW   = EXP_W + 3,
  localparam int SW   = PW + GUARD + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic                 sign,
  input  logic signed [XW-1:0] ebig,
  input  logic [SW-1:0]        sum,
  output logic                 v_q,
  output logic [W-1:0]         res_q
);
  localparam int POINT = PW - 2 + GUARD;
  localparam int EMAX  = (1 << EXP_W) - 1;
  localparam logic [W-2:0] MAX_MAG = {EXP_W'(EMAX - 1), {MAN_W{1'b1}}};

  int            lead;
  int            er;
  logic [SW-1:0] norm;
  logic [W-1:0]  res_d;

  always_comb begin
    lead = 0;
    for (int i = 0; i < SW; i++)
      if (sum[i]) lead = i;
    er   = int'(ebig) - POINT + lead;
    norm = sum << (SW - 1 - lead);
    if (sum == '0)
      res_d = '0;
    else if (er <= 0)
      res_d = {sign, {(W-1){1'b0}}};
    else if (er >= EMAX)
      res_d = {sign, MAX_MAG};
    else
      res_d = {sign, EXP_W'(er), norm[SW-2 -: MAN_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= v_in;
    res_q <= res_d;
  end

  // R9
  no_top_exp_chk: assert property (@(posedge clk) disable iff (rst)
    v_q |-> (res_q[W-2 -: EXP_W] != {EXP_W{1'b1}}));
  // R8
  flush_sub_chk: assert property (@(posedge clk) disable iff (rst)
    v_q |-> (res_q[W-2 -: EXP_W] != '0 || res_q[MAN_W-1:0] == '0));
  // R10
  cancel_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (v_in && sum == '0) |=> (v_q && res_q == '0));
endmodule

// File: rtl/hmac_unit.sv
`timescale 1ns/1ps
module hmac_unit #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int GUARD = 3,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int PW   = 2 * (MAN_W + 1),
  localparam int XW   = EXP_W + 3,
  localparam int SW   = PW + GUARD + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic         out_valid,
  output logic [W-1:0] d
);
  logic                 v1, p_sign, p_zero, s_sign, s_zero;
  logic signed [XW-1:0] p_exp, s_exp;
  logic [PW-1:0]        p_man;
  logic [MAN_W:0]       s_man;
  logic                 v2, sign2;
  logic signed [XW-1:0] ebig2;
  logic [SW-1:0]        sum2;

  hmac_mul_stage #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .a(a), .b(b), .c(c),
    .v_q(v1), .p_sign_q(p_sign), .p_zero_q(p_zero), .p_exp_q(p_exp),
    .p_man_q(p_man), .s_sign_q(s_sign), .s_zero_q(s_zero),
    .s_exp_q(s_exp), .s_man_q(s_man));

  hmac_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_add (
    .clk(clk), .rst(rst), .v_in(v1),
    .p_sign(p_sign), .p_zero(p_zero), .p_exp(p_exp), .p_man(p_man),
    .s_sign(s_sign), .s_zero(s_zero), .s_exp(s_exp), .s_man(s_man),
    .v_q(v2), .sign_q(sign2), .ebig_q(ebig2), .sum_q(sum2));

  hmac_normalize #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_norm (
    .clk(clk), .rst(rst), .v_in(v2), .sign(sign2), .ebig(ebig2),
    .sum(sum2), .v_q(out_valid), .res_q(d));

  // R6
  latency3_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(rst, 3))
      |-> (out_valid == $past(in_valid, 3)));
  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/sim_hmac_unit.sv
`timescale 1ns/1ps
module sim_hmac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] a = '0, b = '0, c = '0;
  logic        out_valid;
  logic [15:0] d;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hmac_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
                .a(a), .b(b), .c(c), .out_valid(out_valid), .d(d));

  task automatic check(input string tag, input logic [15:0] got,
                       input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // issue one operation, confirm nothing early, sample after three edges
  task automatic run_op(input string tag, input logic [2:0] o,
                        input logic [15:0] va, input logic [15:0] vb,
                        input logic [15:0] vc, input logic [15:0] exp);
    @(negedge clk);
    op = o; a = va; b = vb; c = vc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; a = 16'hDEAD; b = 16'hBEEF; c = 16'hCAFE;
    @(negedge clk);
    check({tag, " early valid (R6)"}, {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check({tag, " valid"}, {15'd0, out_valid}, 16'd1);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    check("R11 valid in reset", {15'd0, out_valid}, 16'd0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 valid after reset", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_mac;
    run_op("R1 1+2*3", 3'd0, 16'h3C00, 16'h4000, 16'h4200, 16'h4700);
    run_op("R1 opcode 6 as mac", 3'd6, 16'h3C00, 16'h4000, 16'h4200, 16'h4700);
  endtask

  task automatic t_msu;
    run_op("R2 1-2*3", 3'd1, 16'h3C00, 16'h4000, 16'h4200, 16'hC500);
  endtask

  task automatic t_add;
    run_op("R3 1.5+2 c ignored", 3'd2, 16'h3E00, 16'h4000, 16'h1234, 16'h4300);
  endtask

  task automatic t_sub;
    run_op("R4 1-3 c ignored", 3'd3, 16'h3C00, 16'h4200, 16'h7777, 16'hC000);
  endtask

  task automatic t_mul;
    run_op("R5 1.5*4 a ignored", 3'd4, 16'h5555, 16'h3E00, 16'h4400, 16'h4600);
  endtask

  task automatic t_trunc;
    run_op("R7 sticky borrow", 3'd1, 16'h4400, 16'h3C01, 16'h3401, 16'h437F);
  endtask

  task automatic t_flush;
    run_op("R8 subnormal b", 3'd4, 16'h0000, 16'h0200, 16'h4000, 16'h0000);
    run_op("R8 subnormal a", 3'd2, 16'h0001, 16'h3C00, 16'h0000, 16'h3C00);
    run_op("R8 underflow neg", 3'd4, 16'h0000, 16'h8400, 16'h3800, 16'h8000);
  endtask

  task automatic t_sat;
    run_op("R9 overflow pos", 3'd4, 16'h0000, 16'h7800, 16'h4000, 16'h7BFF);
    run_op("R9 overflow neg", 3'd0, 16'h0000, 16'hF800, 16'h4000, 16'hFBFF);
  endtask

  task automatic t_cancel;
    run_op("R10 2-1*2", 3'd1, 16'h4000, 16'h3C00, 16'h4000, 16'h0000);
    run_op("R10 -3+3", 3'd2, 16'hC200, 16'h4200, 16'h0000, 16'h0000);
  endtask

  task automatic t_stream;
    logic [2:0]  so [4] = '{3'd0, 3'd2, 3'd4, 3'd3};
    logic [15:0] sa [4] = '{16'h3C00, 16'h3800, 16'h0000, 16'h4400};
    logic [15:0] sb [4] = '{16'h4000, 16'h3800, 16'h4200, 16'h4000};
    logic [15:0] sc [4] = '{16'h4000, 16'h0000, 16'h4200, 16'h0000};
    logic [15:0] se [4] = '{16'h4500, 16'h3C00, 16'h4880, 16'h4000};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i >= 3 && i < 7) begin
        check("R6 stream valid", {15'd0, out_valid}, 16'd1);
        check("R6 stream data", d, se[i-3]);
      end
      if (i == 7) check("R6 stream end", {15'd0, out_valid}, 16'd0);
      if (i < 4) begin
        op = so[i]; a = sa[i]; b = sb[i]; c = sc[i]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    t_mac();
    t_msu();
    t_add();
    t_sub();
    t_mul();
    t_trunc();
    t_flush();
    t_sat();
    t_cancel();
    t_stream();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule